// File: doc/BRIEF.md
# Four-Core Snooping Write-Through Cache Cluster

This block gives four cores each a small private data cache, all backed by one shared main memory reached over a single inter-core bus. A round-robin arbiter hands the bus to one core per cycle. Every store is written through: main memory and the storing core's own copy change in the same bus cycle. Every other cache watches the bus, and a run-time policy input chooses how each of them reacts to a foreign store. In drop mode a cache holding that address marks the copy invalid. In refresh mode it overwrites the copy with the broadcast word and keeps it valid.

Each core has a valid/ready request port. A request, with its write flag, word address and store data, must be held steady while `req_valid` is high until the core sees `req_ready` high at a rising edge. A load that hits is accepted in the same cycle without using the bus. Load misses and all stores wait for a bus grant, and that wait is the only back-pressure. Each accepted request gives exactly one `resp_valid` pulse on the next cycle. The response cannot be stalled. Three counters report bus traffic for each policy and the number of copies dropped, so traffic under the two policies can be compared.

Top module: `snoop_wt_cluster`

## Requirements
- R1: A load that misses takes the bus, reads the word from main memory, installs it in the core's cache, and returns it with `resp_valid` high in the cycle after acceptance.
- R2: A load that hits is accepted in the cycle it is presented, even while other cores are competing for the bus.
- R3: A store writes main memory and, if present, the storer's own cached copy. A store that misses does not allocate a line. The response to a store returns the stored word.
- R4: With `policy_refresh` = 0, a store from one core invalidates every other cache's valid copy of that address, each dropped copy adds one to `drop_count`, and a later load of that address by those cores returns the new value from memory.
- R5: With `policy_refresh` = 1, a store from one core overwrites other caches' copies, which stay valid. `drop_count` does not change, and later loads return the new value.
- R6: A core's own store never invalidates its own copy. After its store it reads back the stored value, and `drop_count` does not change.
- R7: Any number of caches may hold the same address at once. One store in drop mode removes all of the other copies.
- R8: Every bus store adds one to `inval_bcast_count` in drop mode or to `refresh_bcast_count` in refresh mode. A repeated store to an address that has already been invalidated drops no further copies.
- R9: When all four cores need the bus together, each is granted exactly once in four consecutive cycles.
- R10: If a load hits a line that another core's bus store is targeting in the same cycle, the bus store takes effect first: the load is held one cycle and returns the stored value.
- R11: After reset, no responses are pending, all counters are zero, all caches are empty and memory reads as zero.
- R12: A request that is not granted sees `req_ready` low and must hold its fields until it is accepted. No request is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_refresh | input | 1 | 0 = drop other copies on a store, 1 = overwrite other copies |
| req_valid | input | 4 | Per-core request valid |
| req_ready | output | 4 | Per-core request accepted this cycle |
| req_write | input | 4 | Per-core 1 = store, 0 = load |
| req_addr | input | 32 | Per-core word address, 8 bits each (core c at bits 8c+7:8c) |
| req_wdata | input | 128 | Per-core store data, 32 bits each |
| resp_valid | output | 4 | Per-core response pulse, one cycle after acceptance |
| resp_rdata | output | 128 | Per-core load data or echoed store data, 32 bits each |
| inval_bcast_count | output | 16 | Bus stores issued in drop mode |
| refresh_bcast_count | output | 16 | Bus stores issued in refresh mode |
| drop_count | output | 16 | Total cached copies invalidated by snooping |

## Verification
The hardest case to reach from the ports is a load hit and a foreign bus store colliding on the same line in the same cycle. The bench reaches it by first loading the line into one core, then presenting that core's load and another core's store on the same clock edge. The store is the only bus requester, so it is granted immediately. The bench then checks that the load waited exactly one cycle and returned the new value, in both policies. A second hard case is telling a hit from a miss. The bench does this by surrounding a hit with three contending bus requests and requiring that the hit is accepted at once, and it uses `drop_count` deltas to show which cores held copies.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic {
    POL_DROP    = 1'b0,
    POL_REFRESH = 1'b1
  } coh_policy_e;

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/coh_rr_arbiter.sv
module coh_rr_arbiter #(
  parameter int NREQ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req,
  output logic [NREQ-1:0] grant
);
  localparam int PW = coh_pkg::idx_bits(NREQ);

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] win;
  logic          found;
  int            k;

  always_comb begin
    grant = '0;
    win   = ptr_q;
    found = 1'b0;
    k     = 0;
    for (int i = 0; i < NREQ; i++) begin
      k = (int'(ptr_q) + i) % NREQ;
      if (!found && req[k]) begin
        grant[k] = 1'b1;
        win      = PW'(k);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (found) begin
      ptr_q <= (int'(win) == NREQ - 1) ? '0 : PW'(int'(win) + 1);
    end
  end

  assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_only_requested_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);
  assert_winner_not_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (found && $countones(req) > 1) |=> (grant != $past(grant)) || !$stable(req));
endmodule

// File: rtl/coh_main_mem.sv
module coh_main_mem #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  assign rdata = mem_q[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[addr] <= wdata;
    end
  end

  assert_write_through_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem_q[$past(addr)] == $past(wdata));
endmodule

// File: rtl/coh_cache.sv
module coh_cache #(
  parameter int NCORE = 4,
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int LINES = 16,
  parameter int ID    = 0
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  coh_pkg::coh_policy_e                policy,
  input  logic                                req_valid,
  input  logic                                req_write,
  input  logic [AW-1:0]                       req_addr,
  input  logic [DW-1:0]                       req_wdata,
  input  logic                                grant,
  input  logic                                bus_valid,
  input  logic                                bus_write,
  input  logic [coh_pkg::idx_bits(NCORE)-1:0] bus_owner,
  input  logic [AW-1:0]                       bus_addr,
  input  logic [DW-1:0]                       bus_wdata,
  input  logic [DW-1:0]                       mem_rdata,
  output logic                                need_bus,
  output logic                                req_ready,
  output logic                                resp_valid,
  output logic [DW-1:0]                       resp_rdata,
  output logic                                snoop_drop
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW;
  localparam int OW = coh_pkg::idx_bits(NCORE);

  logic          valid_q [LINES];
  logic [TW-1:0] tag_q   [LINES];
  logic [DW-1:0] data_q  [LINES];

  logic [IW-1:0] idx, sidx;
  logic [TW-1:0] tag, stag;
  logic          local_hit, foreign_store, snoop_hit, line_busy, hit_serve;

  assign idx  = req_addr[IW-1:0];
  assign tag  = req_addr[AW-1:IW];
  assign sidx = bus_addr[IW-1:0];
  assign stag = bus_addr[AW-1:IW];

  assign local_hit     = valid_q[idx] && (tag_q[idx] == tag);
  assign foreign_store = bus_valid && bus_write && (bus_owner != OW'(ID));
  assign snoop_hit     = foreign_store && valid_q[sidx] && (tag_q[sidx] == stag);
  assign line_busy     = foreign_store && (sidx == idx);
  assign hit_serve     = req_valid && !req_write && local_hit && !line_busy;
  assign need_bus      = req_valid && (req_write || !local_hit);
  assign req_ready     = hit_serve || grant;
  assign snoop_drop    = snoop_hit && (policy == coh_pkg::POL_DROP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        valid_q[i] <= 1'b0;
        tag_q[i]   <= '0;
        data_q[i]  <= '0;
      end
      resp_valid <= 1'b0;
      resp_rdata <= '0;
    end else begin
      if (snoop_hit) begin
        if (policy == coh_pkg::POL_REFRESH) data_q[sidx] <= bus_wdata;
        else                                valid_q[sidx] <= 1'b0;
      end
      if (grant) begin
        if (!req_write) begin
          valid_q[idx] <= 1'b1;
          tag_q[idx]   <= tag;
          data_q[idx]  <= mem_rdata;
        end else if (local_hit) begin
          data_q[idx] <= req_wdata;
        end
      end
      resp_valid <= req_valid && req_ready;
      if (hit_serve)      resp_rdata <= data_q[idx];
      else if (req_write) resp_rdata <= req_wdata;
      else                resp_rdata <= mem_rdata;
    end
  end

  assert_drop_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_drop |=> !valid_q[$past(sidx)]);
  assert_refresh_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_hit && policy == coh_pkg::POL_REFRESH)
      |=> valid_q[$past(sidx)] && data_q[$past(sidx)] == $past(bus_wdata));
  assert_fill_installs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !req_write) |=> valid_q[$past(idx)] && resp_rdata == data_q[$past(idx)]);
  assert_grant_needs_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> need_bus && bus_valid && bus_owner == OW'(ID));
  assert_one_response_R12: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req_valid));
endmodule

// File: rtl/snoop_wt_cluster.sv
module snoop_wt_cluster #(
  parameter int NCORE = 4,
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int LINES = 16,
  parameter int CW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                policy_refresh,
  input  logic [NCORE-1:0]    req_valid,
  output logic [NCORE-1:0]    req_ready,
  input  logic [NCORE-1:0]    req_write,
  input  logic [NCORE*AW-1:0] req_addr,
  input  logic [NCORE*DW-1:0] req_wdata,
  output logic [NCORE-1:0]    resp_valid,
  output logic [NCORE*DW-1:0] resp_rdata,
  output logic [CW-1:0]       inval_bcast_count,
  output logic [CW-1:0]       refresh_bcast_count,
  output logic [CW-1:0]       drop_count
);
  localparam int OW = coh_pkg::idx_bits(NCORE);

  coh_pkg::coh_policy_e policy;
  assign policy = coh_pkg::coh_policy_e'(policy_refresh);

  logic [NCORE-1:0] need, grant, drops;
  logic             bus_valid, bus_write;
  logic [OW-1:0]    bus_owner;
  logic [AW-1:0]    bus_addr;
  logic [DW-1:0]    bus_wdata, mem_rdata;

  coh_rr_arbiter #(.NREQ(NCORE)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(need), .grant(grant)
  );

  always_comb begin
    bus_valid = |grant;
    bus_owner = '0;
    bus_write = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    for (int c = 0; c < NCORE; c++) begin
      if (grant[c]) begin
        bus_owner = OW'(c);
        bus_write = req_write[c];
        bus_addr  = req_addr[c*AW +: AW];
        bus_wdata = req_wdata[c*DW +: DW];
      end
    end
  end

  coh_main_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_valid && bus_write),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(mem_rdata)
  );

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    coh_cache #(.NCORE(NCORE), .AW(AW), .DW(DW), .LINES(LINES), .ID(c)) u_cache (
      .clk(clk), .rst_n(rst_n), .policy(policy),
      .req_valid(req_valid[c]), .req_write(req_write[c]),
      .req_addr(req_addr[c*AW +: AW]), .req_wdata(req_wdata[c*DW +: DW]),
      .grant(grant[c]), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_owner(bus_owner), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .mem_rdata(mem_rdata), .need_bus(need[c]), .req_ready(req_ready[c]),
      .resp_valid(resp_valid[c]), .resp_rdata(resp_rdata[c*DW +: DW]),
      .snoop_drop(drops[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inval_bcast_count   <= '0;
      refresh_bcast_count <= '0;
      drop_count          <= '0;
    end else begin
      if (bus_valid && bus_write) begin
        if (policy == coh_pkg::POL_REFRESH) refresh_bcast_count <= refresh_bcast_count + 1'b1;
        else                                inval_bcast_count   <= inval_bcast_count + 1'b1;
      end
      drop_count <= drop_count + CW'($countones(drops));
    end
  end

  assert_inval_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inval_bcast_count != $past(inval_bcast_count))
      |-> $past(bus_valid && bus_write && !policy_refresh));
  assert_no_drop_in_refresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
    policy_refresh |-> drops == '0);
  assert_owner_never_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (drops & grant) == '0);
  assert_drops_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(drops) <= NCORE - 1);
endmodule

// File: tb/snoop_wt_cluster_bench.sv
`timescale 1ns/1ps
module snoop_wt_cluster_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n, policy_refresh;
  logic [3:0]   req_valid, req_ready, req_write, resp_valid;
  logic [31:0]  req_addr;
  logic [127:0] req_wdata, resp_rdata;
  logic [15:0]  inval_bcast_count, refresh_bcast_count, drop_count;

  logic        b_valid [4];
  logic        b_write [4];
  logic [7:0]  b_addr  [4];
  logic [31:0] b_wdata [4];
  logic [31:0] mem_m [256];
  int total = 0, bad = 0, cyc = 0;

  always_comb begin
    for (int c = 0; c < 4; c++) begin
      req_valid[c]          = b_valid[c];
      req_write[c]          = b_write[c];
      req_addr[c*8 +: 8]    = b_addr[c];
      req_wdata[c*32 +: 32] = b_wdata[c];
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  snoop_wt_cluster u_snoop_wt_cluster (
    .clk(clk), .rst_n(rst_n), .policy_refresh(policy_refresh),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid),
    .resp_rdata(resp_rdata), .inval_bcast_count(inval_bcast_count),
    .refresh_bcast_count(refresh_bcast_count), .drop_count(drop_count)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input int c, input logic wr, input logic [7:0] a,
                       input logic [31:0] d, output logic [31:0] rd,
                       output int acc, output int waits);
    @(negedge clk);
    b_valid[c] = 1'b1; b_write[c] = wr; b_addr[c] = a; b_wdata[c] = d;
    waits = 0;
    forever begin
      #1;
      if (req_ready[c]) break;
      waits++;
      @(negedge clk);
    end
    acc = cyc;
    @(negedge clk);
    check("R12 one response per request", {31'd0, resp_valid[c]}, 32'd1);
    rd = resp_rdata[c*32 +: 32];
    b_valid[c] = 1'b0;
    if (wr) mem_m[a] = d;
  endtask

  task automatic ld(input int c, input logic [7:0] a, input string tag);
    logic [31:0] rd; int acc, w;
    issue(c, 1'b0, a, 32'd0, rd, acc, w);
    check(tag, rd, mem_m[a]);
  endtask

  task automatic st(input int c, input logic [7:0] a, input logic [31:0] d);
    logic [31:0] rd; int acc, w;
    issue(c, 1'b1, a, d, rd, acc, w);
    check("R3 store echoes data", rd, d);
  endtask

  task automatic t_reset;
    check("R11 no response after reset", {28'd0, resp_valid}, 32'd0);
    check("R11 inval count zero", {16'd0, inval_bcast_count}, 32'd0);
    check("R11 refresh count zero", {16'd0, refresh_bcast_count}, 32'd0);
    check("R11 drop count zero", {16'd0, drop_count}, 32'd0);
    ld(0, 8'h05, "R11 memory reads zero");
  endtask

  task automatic t_fill;
    st(3, 8'h21, 32'hCAFE0021);
    ld(0, 8'h21, "R1 miss fill core0");
    ld(2, 8'h21, "R1 miss fill core2");
    ld(0, 8'h21, "R1 repeat load core0");
  endtask

  task automatic t_no_allocate;
    logic [15:0] d0, i0;
    d0 = drop_count; i0 = inval_bcast_count;
    st(1, 8'h21, 32'h11112222);
    check("R3 store miss did not allocate (2 drops)", {16'd0, drop_count - d0}, 32'd2);
    check("R8 one drop-mode broadcast", {16'd0, inval_bcast_count - i0}, 32'd1);
    ld(3, 8'h21, "R3 written through to memory");
  endtask

  task automatic t_sharers;
    logic [15:0] d0, i0;
    for (int c = 0; c < 4; c++) ld(c, 8'h42, "R7 shared load");
    d0 = drop_count; i0 = inval_bcast_count;
    st(0, 8'h42, 32'hA5A50042);
    check("R7 all three other copies dropped", {16'd0, drop_count - d0}, 32'd3);
    st(0, 8'h42, 32'hA5A50043);
    st(0, 8'h42, 32'hA5A50044);
    check("R8 repeated stores drop nothing more", {16'd0, drop_count - d0}, 32'd3);
    check("R8 every store counted", {16'd0, inval_bcast_count - i0}, 32'd3);
    for (int c = 1; c < 4; c++) ld(c, 8'h42, "R4 refetch after drop");
    ld(0, 8'h42, "R3 own copy updated");
  endtask

  task automatic t_own;
    logic [15:0] d0;
    ld(2, 8'h63, "R6 prime own copy");
    d0 = drop_count;
    st(2, 8'h63, 32'h0B0B0063);
    check("R6 own store drops nothing", {16'd0, drop_count - d0}, 32'd0);
    ld(2, 8'h63, "R6 own copy holds stored value");
  endtask

  task automatic t_refresh;
    logic [15:0] d0, u0, i0;
    policy_refresh = 1'b1;
    for (int c = 0; c < 4; c++) ld(c, 8'h84, "R5 shared load");
    d0 = drop_count; u0 = refresh_bcast_count; i0 = inval_bcast_count;
    st(2, 8'h84, 32'h77770084);
    st(2, 8'h84, 32'h77770085);
    check("R5 no drops in refresh mode", {16'd0, drop_count - d0}, 32'd0);
    check("R8 refresh broadcasts counted", {16'd0, refresh_bcast_count - u0}, 32'd2);
    check("R8 drop-mode count unchanged", {16'd0, inval_bcast_count - i0}, 32'd0);
    for (int c = 0; c < 4; c++) ld(c, 8'h84, "R5 refreshed copy read");
    policy_refresh = 1'b0;
  endtask

  task automatic t_collide(input logic mode, input logic [31:0] v);
    logic [31:0] r0, r1; int a0, a1, w0, w1;
    policy_refresh = mode;
    ld(1, 8'hA5, "R10 prime line");
    fork
      issue(0, 1'b1, 8'hA5, v, r0, a0, w0);
      issue(1, 1'b0, 8'hA5, 32'd0, r1, a1, w1);
    join
    check("R10 load sees bus store first", r1, v);
    check("R10 load held one cycle", w1, 32'd1);
    check("R10 store granted at once", w0, 32'd0);
    policy_refresh = 1'b0;
  endtask

  task automatic t_round_robin;
    logic [31:0] r [4]; int acc [4]; int w [4]; int mn, mx, ws;
    fork
      issue(0, 1'b1, 8'hD0, 32'hD0D0_0000, r[0], acc[0], w[0]);
      issue(1, 1'b1, 8'hD1, 32'hD1D1_0001, r[1], acc[1], w[1]);
      issue(2, 1'b1, 8'hD2, 32'hD2D2_0002, r[2], acc[2], w[2]);
      issue(3, 1'b1, 8'hD3, 32'hD3D3_0003, r[3], acc[3], w[3]);
    join
    mn = acc[0]; mx = acc[0]; ws = 0;
    for (int c = 0; c < 4; c++) begin
      if (acc[c] < mn) mn = acc[c];
      if (acc[c] > mx) mx = acc[c];
      ws += w[c];
    end
    check("R9 grants span four cycles", mx - mn, 32'd3);
    check("R12 total wait cycles", ws, 32'd6);
    for (int c = 0; c < 4; c++) ld(c ^ 1, 8'hD0 + 8'(c), "R12 every store landed");
  endtask

  task automatic t_hit_under_contention;
    logic [31:0] r [4]; int acc [4]; int w [4];
    ld(1, 8'hC6, "R2 prime line");
    fork
      issue(0, 1'b1, 8'hE0, 32'hE0, r[0], acc[0], w[0]);
      issue(1, 1'b0, 8'hC6, 32'd0, r[1], acc[1], w[1]);
      issue(2, 1'b1, 8'hE2, 32'hE2, r[2], acc[2], w[2]);
      issue(3, 1'b1, 8'hE3, 32'hE3, r[3], acc[3], w[3]);
    join
    check("R2 hit accepted at once", w[1], 32'd0);
    check("R2 hit data", r[1], mem_m[8'hC6]);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem_m[i] = 32'd0;
    for (int c = 0; c < 4; c++) begin
      b_valid[c] = 1'b0; b_write[c] = 1'b0; b_addr[c] = '0; b_wdata[c] = '0;
    end
    policy_refresh = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset;
    t_fill;
    t_no_allocate;
    t_sharers;
    t_own;
    t_refresh;
    t_collide(1'b0, 32'h5151_00A5);
    t_collide(1'b1, 32'h6262_00A5);
    t_round_robin;
    t_hit_under_contention;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R12 watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule